// File: doc/BRIEF.md
# Input Change Latch with Held and Previous Registers

This block watches a bank of digital inputs for a host that may be busy or asleep. Each input first passes through a synchronizer. The block then compares it with a per-bit "held" latch. When an input moves, its held bit takes the new level and freezes there until the host reads the held register. Further movement on that input is ignored in the meantime. A second "previous" register keeps the levels from before the change. A read of the held register moves each held bit into the previous register and rearms the latch. A read of the previous register is only a look and changes nothing.

When any watched input changes, the active-low change flag goes low. It stays low until the host has strobed all three reads since the flag last fell: status, previous and held. The reads may come in any order, or together. The upper inputs can be masked. A masked input raises no flag and no reset request, and its register bits simply follow the live level. In standby a change also sends a one-cycle reset request to the reset generator. In run mode it does not.

The flag logic is a two-state machine with these states:
- `CI_IDLE`: the flag is high. It moves to `CI_PENDING` on any unmasked change.
- `CI_PENDING`: the flag is low. It records which reads have been seen. It returns to `CI_IDLE` once all three are recorded. Another change while pending clears the record and stays in `CI_PENDING`.

Top module: `input_change_latch`

## Requirements
- R1: When an unmasked input differs from its held bit and that bit is not frozen, the held bit takes the synchronized level and freezes. Later changes on that input leave `new_reg` unchanged until `rd_new` is strobed.
- R2: A cycle with `rd_new` high copies every held bit into `old_reg` and unfreezes it. An input that already differs from its held bit is captured again in the following cycle.
- R3: A strobe on `rd_old` alone leaves `old_reg`, `new_reg` and `chg_n` unchanged.
- R4: An unmasked input change drives `chg_n` low. With the two-stage synchronizer, this happens after the third rising clock edge following the input edge, together with the update of `new_reg`.
- R5: Once low, `chg_n` returns high only after `rd_stat`, `rd_old` and `rd_new` have each been strobed at least once since it fell. It rises right after the edge that completes the set. A new change while `chg_n` is low empties the record.
- R6: `mask_hi[k]` masks input `din[4+k]`. A masked input neither drives `chg_n` low nor raises `rst_req`. Inputs 0 to 3 are never masked.
- R7: While an input is masked, its bits in both `new_reg` and `old_reg` load the synchronized input level every cycle.
- R8: While `rst_n` is low at a clock edge, `new_reg` and `old_reg` load the synchronized inputs, `chg_n` is high and `rst_req` is low. After release, both registers hold the levels from the last reset cycle and all latches are armed.
- R9: With `standby` high, each change event raises `rst_req` for exactly one cycle, in the same cycle that the event is flagged. With `standby` low, `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Raw watched inputs |
| mask_hi | input | 4 | Mask bits for inputs 4 to 7 (1 = masked) |
| standby | input | 1 | 1 = standby mode, where changes also request a reset |
| rd_stat | input | 1 | One-cycle strobe: the status register was read |
| rd_old | input | 1 | One-cycle strobe: the previous register was read |
| rd_new | input | 1 | One-cycle strobe: the held register was read |
| new_reg | output | 8 | Held register contents |
| old_reg | output | 8 | Previous register contents |
| chg_n | output | 1 | Change flag, active low |
| rst_req | output | 1 | One-cycle reset request toward the reset generator |

## Verification
The bench aims at several corner cases, and each one shows a typical fault:
- **Rearm after a held read.** The input moves back while its bit is frozen, and the host then reads the held register. A design that drops this change leaves `chg_n` high and `new_reg` stale one cycle after the read.
- **Change during a partial read sequence.** A new change arrives after the status and previous reads but before the held read. A design that keeps the stale record releases `chg_n` too early.
- **Mask handling.** The mask is applied to a low input and to a frozen upper input. A design that lets a masked bit raise the flag or the reset request is reported, and so is one that stops tracking a masked bit.
- **Timing.** Seeded random reads, input toggles, mask changes and mode changes are compared cycle by cycle with a bench-side model. This catches off-by-one latency and wrong priority between a read and a change in the same cycle.

// File: rtl/icl_pkg.sv
package icl_pkg;

    typedef enum logic {
        CI_IDLE    = 1'b0,
        CI_PENDING = 1'b1
    } ci_state_t;

    // read-record bit positions
    localparam int SEEN_NEW  = 0;
    localparam int SEEN_OLD  = 1;
    localparam int SEEN_STAT = 2;
    localparam int SEEN_W    = 3;

endpackage

// File: rtl/icl_sync.sv
module icl_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int k = 1; k < STAGES; k++) begin
            stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/icl_bit_cell.sv
module icl_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    input  logic msk,
    input  logic rd_new,
    output logic new_q,
    output logic old_q,
    output logic evt
);

    logic frozen;

    assign evt = !msk && !rd_new && !frozen && (s != new_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q  <= s;
            old_q  <= s;
            frozen <= 1'b0;
        end else if (msk) begin
            new_q  <= s;
            old_q  <= s;
            frozen <= 1'b0;
        end else if (rd_new) begin
            old_q  <= new_q;
            frozen <= 1'b0;
        end else if (evt) begin
            new_q  <= s;
            frozen <= 1'b1;
        end
    end

    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !rd_new && !msk) |=> $stable(new_q)); // R1
    AST_OLD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_new && !msk) |=> $stable(old_q)); // R3
    AST_MASK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        msk |=> (new_q == $past(s) && old_q == $past(s))); // R7

endmodule

// File: rtl/icl_readseq.sv
module icl_readseq
    import icl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_any,
    input  logic standby,
    input  logic rd_stat,
    input  logic rd_old,
    input  logic rd_new,
    output logic chg_n,
    output logic rst_req
);

    ci_state_t          state_q, state_d;
    logic [SEEN_W-1:0]  seen_q, seen_d, seen_now;
    logic               req_q;

    always_comb begin
        seen_now            = seen_q;
        seen_now[SEEN_NEW]  = seen_q[SEEN_NEW]  | rd_new;
        seen_now[SEEN_OLD]  = seen_q[SEEN_OLD]  | rd_old;
        seen_now[SEEN_STAT] = seen_q[SEEN_STAT] | rd_stat;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        unique case (state_q)
            CI_IDLE: begin
                seen_d = '0;
                if (evt_any) state_d = CI_PENDING;
            end
            CI_PENDING: begin
                if (evt_any) begin
                    seen_d = '0;
                end else if (&seen_now) begin
                    state_d = CI_IDLE;
                    seen_d  = '0;
                end else begin
                    seen_d = seen_now;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CI_IDLE;
            seen_q  <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
            req_q   <= evt_any && standby;
        end
    end

    // output process
    always_comb begin
        chg_n   = (state_q != CI_PENDING);
        rst_req = req_q;
    end

    AST_RISE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_n) |-> $past(rd_stat || rd_old || rd_new)); // R5

endmodule

// File: rtl/input_change_latch.sv
module input_change_latch #(
    parameter int WIDTH    = 8,
    parameter int MASKABLE = 4,
    parameter int SYNC_ST  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIDTH-1:0]    din,
    input  logic [MASKABLE-1:0] mask_hi,
    input  logic                standby,
    input  logic                rd_stat,
    input  logic                rd_old,
    input  logic                rd_new,
    output logic [WIDTH-1:0]    new_reg,
    output logic [WIDTH-1:0]    old_reg,
    output logic                chg_n,
    output logic                rst_req
);

    localparam int MASK_LO = WIDTH - MASKABLE;

    logic [WIDTH-1:0] s_vec;
    logic [WIDTH-1:0] msk_vec;
    logic [WIDTH-1:0] evt_vec;
    logic             evt_any;

    icl_sync #(.WIDTH(WIDTH), .STAGES(SYNC_ST)) i_sync (
        .clk (clk),
        .d   (din),
        .q   (s_vec)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= MASK_LO) begin : g_maskable
            assign msk_vec[i] = mask_hi[i-MASK_LO];
        end else begin : g_fixed
            assign msk_vec[i] = 1'b0;
        end

        icl_bit_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .s      (s_vec[i]),
            .msk    (msk_vec[i]),
            .rd_new (rd_new),
            .new_q  (new_reg[i]),
            .old_q  (old_reg[i]),
            .evt    (evt_vec[i])
        );
    end

    assign evt_any = |evt_vec;

    icl_readseq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_any (evt_any),
        .standby (standby),
        .rd_stat (rd_stat),
        .rd_old  (rd_old),
        .rd_new  (rd_new),
        .chg_n   (chg_n),
        .rst_req (rst_req)
    );

    AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_n) |-> $past(evt_any)); // R4
    AST_REQ_ONLY_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(standby) && !chg_n)); // R9
    AST_MASKED_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chg_n) && !chg_n) |-> ($past(evt_vec & ~msk_vec) != '0)); // R6

endmodule

// File: tb/test_input_change_latch.sv
`timescale 1ns/1ps
module test_input_change_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'hA5;
    logic [3:0] mask_hi = 4'h0;
    logic       standby = 1'b0;
    logic       rd_stat = 1'b0, rd_old = 1'b0, rd_new = 1'b0;
    logic [7:0] new_reg, old_reg;
    logic       chg_n, rst_req;

    int tests = 0;
    int fails = 0;
    int pulse_cnt = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    input_change_latch i_input_change_latch (
        .clk(clk), .rst_n(rst_n), .din(din), .mask_hi(mask_hi),
        .standby(standby), .rd_stat(rd_stat), .rd_old(rd_old), .rd_new(rd_new),
        .new_reg(new_reg), .old_reg(old_reg), .chg_n(chg_n), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [7:0] nw;
        logic [7:0] od;
        logic [7:0] fz;
        logic       pend;
        logic [2:0] seen;   // {stat, old, new}
        logic       req;
    } mdl_t;

    function automatic mdl_t mdl_step(mdl_t c, logic [7:0] s, logic [3:0] mh,
                                      logic sb, logic rs, logic ro, logic rn);
        mdl_t n = c;
        logic [7:0] m = {mh, 4'b0000};
        logic ev = 1'b0;
        logic [2:0] sn;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                n.nw[i] = s[i]; n.od[i] = s[i]; n.fz[i] = 1'b0;
            end else if (rn) begin
                n.od[i] = c.nw[i]; n.fz[i] = 1'b0;
            end else if (!c.fz[i] && s[i] != c.nw[i]) begin
                n.nw[i] = s[i]; n.fz[i] = 1'b1; ev = 1'b1;
            end
        end
        sn = c.seen | {rs, ro, rn};
        if (!c.pend) begin
            n.seen = 3'b000;
            if (ev) n.pend = 1'b1;
        end else if (ev) begin
            n.seen = 3'b000;
        end else if (&sn) begin
            n.pend = 1'b0; n.seen = 3'b000;
        end else begin
            n.seen = sn;
        end
        n.req = ev & sb;
        return n;
    endfunction

    logic [7:0] m_s1, m_s2;
    mdl_t       mdl;

    always @(posedge clk) begin
        m_s1 <= din;
        m_s2 <= m_s1;
        if (!rst_n) begin
            mdl <= '{nw: m_s2, od: m_s2, fz: 8'h00, pend: 1'b0, seen: 3'b000, req: 1'b0};
        end else begin
            mdl <= mdl_step(mdl, m_s2, mask_hi, standby, rd_stat, rd_old, rd_new);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_req === 1'b1) pulse_cnt++;
        if (cmp_en && rst_n) begin
            chk("R1 model new_reg", {24'h0, new_reg}, {24'h0, mdl.nw});
            chk("R2 model old_reg", {24'h0, old_reg}, {24'h0, mdl.od});
            chk("R5 model chg_n", {31'h0, chg_n}, {31'h0, !mdl.pend});
            chk("R9 model rst_req", {31'h0, rst_req}, {31'h0, mdl.req});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_din(input logic [7:0] v);
        @(negedge clk);
        din = v;
        cyc(3);
    endtask

    task automatic strobe(input logic s, input logic o, input logic n);
        @(negedge clk);
        rd_stat = s; rd_old = o; rd_new = n;
        @(negedge clk);
        rd_stat = 1'b0; rd_old = 1'b0; rd_new = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int p0;
        cyc(6);
        rst_n = 1'b1;
        cyc(1);
        cmp_en = 1'b1;
        // R8: reset state
        chk("R8 new after reset", {24'h0, new_reg}, 32'hA5);
        chk("R8 old after reset", {24'h0, old_reg}, 32'hA5);
        chk("R8 chg_n after reset", {31'h0, chg_n}, 32'h1);
        chk("R8 rst_req after reset", {31'h0, rst_req}, 32'h0);

        // R1/R4: change on bit 0
        set_din(8'hA4);
        chk("R1 new captures", {24'h0, new_reg}, 32'hA4);
        chk("R4 chg_n low", {31'h0, chg_n}, 32'h0);
        set_din(8'hA5);
        chk("R1 new holds while frozen", {24'h0, new_reg}, 32'hA4);
        // R3: old read has no effect
        strobe(1'b0, 1'b1, 1'b0);
        chk("R3 old unchanged", {24'h0, old_reg}, 32'hA5);
        chk("R3 new unchanged", {24'h0, new_reg}, 32'hA4);
        chk("R3 chg_n unchanged", {31'h0, chg_n}, 32'h0);
        strobe(1'b1, 1'b0, 1'b0);
        chk("R5 still low before new read", {31'h0, chg_n}, 32'h0);
        strobe(1'b0, 1'b0, 1'b1);
        chk("R2 old gets held", {24'h0, old_reg}, 32'hA4);
        chk("R5 released after full set", {31'h0, chg_n}, 32'h1);
        cyc(1);
        chk("R2 rearm recaptures", {24'h0, new_reg}, 32'hA5);
        chk("R2 rearm flags again", {31'h0, chg_n}, 32'h0);
        strobe(1'b1, 1'b1, 1'b1);
        chk("R5 release on joint read", {31'h0, chg_n}, 32'h1);
        cyc(3);
        chk("R5 stays released", {31'h0, chg_n}, 32'h1);

        // R6/R7: masked bit 5 tracks
        @(negedge clk); mask_hi = 4'b0010;
        set_din(8'h85);
        chk("R7 masked new tracks", {24'h0, new_reg}, 32'h85);
        chk("R7 masked old tracks", {24'h0, old_reg}, 32'h85);
        chk("R6 masked no flag", {31'h0, chg_n}, 32'h1);
        // R6: low bits cannot be masked
        @(negedge clk); mask_hi = 4'hF;
        set_din(8'h81);
        chk("R6 low bit still flags", {31'h0, chg_n}, 32'h0);
        strobe(1'b1, 1'b1, 1'b1);
        @(negedge clk); mask_hi = 4'h0;
        cyc(2);
        chk("R9 no pulse in run mode", pulse_cnt, 32'h0);

        // R9: standby reset request
        @(negedge clk); standby = 1'b1;
        p0 = pulse_cnt;
        set_din(8'h89);
        cyc(1);
        chk("R9 one pulse in standby", pulse_cnt, p0 + 1);
        @(negedge clk); mask_hi = 4'b1000;
        set_din(8'h09);
        cyc(1);
        chk("R6 masked no reset request", pulse_cnt, p0 + 1);
        strobe(1'b1, 1'b1, 1'b1);
        chk("R5 release after standby", {31'h0, chg_n}, 32'h1);
        @(negedge clk); mask_hi = 4'h0; standby = 1'b0;

        // R5: change during partial sequence clears record
        set_din(8'h0B);
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b0, 1'b1, 1'b0);
        set_din(8'h03);
        strobe(1'b0, 1'b0, 1'b1);
        chk("R5 record cleared by change", {31'h0, chg_n}, 32'h0);
        strobe(1'b1, 1'b1, 1'b1);
        chk("R5 release after clear", {31'h0, chg_n}, 32'h1);

        // seeded random phase
        void'($urandom(32'd1305));
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            rd_stat = ($urandom % 8) == 0;
            rd_old  = ($urandom % 8) == 0;
            rd_new  = ($urandom % 8) == 0;
            if (($urandom % 6) == 0) din[$urandom % 8] = ~din[$urandom % 8];
            if (($urandom % 50) == 0) mask_hi = 4'($urandom);
            if (($urandom % 100) == 0) standby = ~standby;
        end
        @(negedge clk);
        rd_stat = 1'b0; rd_old = 1'b0; rd_new = 1'b0;
        cyc(4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule